// File: doc/BRIEF.md
# Port Expansion Bus Cycle Generator

This block sits between a controller's internal port-register path and a narrow external bus. It lets simple off-chip logic (latches for output-only ports, buffers for input-only ports) stand in for port pins that were given to other functions, or add ports that the chip does not have. Each internal port access arrives as one request that carries a port address, a direction flag, byte-lane enables, write data and two configuration bits for the addressed port. The block either runs a single external cycle for it or finishes it internally at once.

An external cycle always begins with one idle clock. Then comes a select phase T1 and a strobe phase T2. The select strobe and the 8-bit address are active through T1 and T2. The read strobe, or the byte-lane write strobes, are active only in T2. Two cases are finished internally and never reach the pins: the port has at least one pin on-chip, or the port is all inputs and the request is a write. The I/O zone has no bursts, so each request is a separate cycle with its own leading idle clock.

The request side is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While an external cycle runs, `req_ready` stays low, which acts as the busy signal. The requester must hold its request fields stable until the request is taken. Completion is a plain one-cycle `rsp_done` pulse with `rsp_rdata`. There is no back-pressure on the response.

Top module: `port_xbus_seq`

## Requirements
- R1: After reset, `xio_sel_n`, `xio_rd_n` and both bits of `xio_wr_n` are high, `xio_data_oe` and `rsp_done` are low, and `req_ready` is high.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the edge that takes an external request up to the cycle in which its `rsp_done` is high. A request held at `req_valid` during that time has no effect on the pins until it is taken.
- R3: In the first cycle after an external request is taken, all strobes are inactive and the data bus is released. In the next two cycles (T1, T2), `xio_sel_n` is low and `xio_addr` carries the request address.
- R4: For an external read, `xio_rd_n` is low in T2 only. `xio_data_in` is captured on the edge that ends T2. `rsp_done` is high for exactly the next cycle, and `rsp_rdata` shows the captured value in that cycle.
- R5: For an external write, `xio_wr_n[i]` is low in T2 only, and only for the lanes with `req_be[i]`=1. Bit 0 is data bits 7:0 and bit 1 is data bits 15:8. `xio_data_oe` is high and `xio_data_out` equals the write data in T1 and T2 only. `xio_data_oe` is low in every other cycle.
- R6: When `req_onchip` is 1, no strobe moves. `rsp_done` is high in the cycle after the request is taken, and `rsp_rdata` is 0.
- R7: A write with `req_all_in`=1 is finished as in R6, with no strobe. A read with `req_all_in`=1 and `req_onchip`=0 runs a normal external cycle.
- R8: Requests never form a burst. `xio_sel_n` is high in the completion cycle. A request taken in that cycle gets its own leading idle clock before its T1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken; low while an external cycle is busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Port register address |
| req_be | input | 2 | Byte-lane enables for writes |
| req_wdata | input | 16 | Write data |
| req_onchip | input | 1 | Addressed port has at least one pin on-chip |
| req_all_in | input | 1 | All pins of the addressed port are inputs |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data; 0 for writes and internally finished requests |
| xio_sel_n | output | 1 | Active-low I/O select |
| xio_addr | output | 8 | External address; 0 outside T1/T2 |
| xio_rd_n | output | 1 | Active-low read strobe |
| xio_wr_n | output | 2 | Active-low byte-lane write strobes |
| xio_data_out | output | 16 | Data driven on writes |
| xio_data_oe | output | 1 | Output enable for the data bus |
| xio_data_in | input | 16 | Data returned by the external device |

## Verification
The bench builds the block with its default widths: an 8-bit address and a 16-bit data bus. This gives two byte lanes, so the per-lane write strobes can be checked with each lane on its own and with both together. The device model returns data that depends on the address, so a capture in the wrong phase or with a stale address gives a visible mismatch. Runs of back-to-back requests, and a request held at valid while the block is busy, exercise the no-burst spacing and the hold-off path.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_ADDR_W = 8;
  localparam int XB_DATA_W = 16;
  localparam int XB_LANES  = XB_DATA_W / 8;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_LEAD = 2'd1,
    XS_T1   = 2'd2,
    XS_T2   = 2'd3
  } xs_state_e;

  typedef struct packed {
    logic                 write;
    logic [XB_ADDR_W-1:0] addr;
    logic [XB_LANES-1:0]  be;
    logic [XB_DATA_W-1:0] wdata;
  } xb_req_t;
endpackage

// File: rtl/xbus_gate.sv
module xbus_gate (
  input  logic write,
  input  logic onchip,
  input  logic all_in,
  output logic suppress
);
  // on-chip pins serve the access; writes to input-only ports go nowhere
  always_comb suppress = onchip | (all_in & write);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go_ext,
  input  logic      go_sup,
  output xs_state_e state,
  output logic      ready,
  output logic      done
);
  xs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      XS_IDLE: if (go_ext) st_d = XS_LEAD;
      XS_LEAD: st_d = XS_T1;
      XS_T1:   st_d = XS_T2;
      XS_T2:   st_d = XS_IDLE;
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= XS_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= (st_q == XS_T2) | go_sup;
    end
  end

  assign state = st_q;
  assign ready = (st_q == XS_IDLE);

  // R3: T1 is always entered from the leading idle clock
  a_r3_lead_before_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_T1) |-> ($past(st_q) == XS_LEAD));
  // R8: a cycle returns to idle straight after T2
  a_r8_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_T2) |=> (st_q == XS_IDLE));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = XB_ADDR_W,
  parameter int DATA_W = XB_DATA_W,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              go_sup,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  xs_state_e         state,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] rdata,
  output logic              sel_n,
  output logic [ADDR_W-1:0] xaddr,
  output logic              rd_n,
  output logic [LANES-1:0]  wr_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  logic              h_write;
  logic [ADDR_W-1:0] h_addr;
  logic [LANES-1:0]  h_be;
  logic [DATA_W-1:0] h_wdata;
  logic              active, strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_write <= 1'b0;
      h_addr  <= '0;
      h_be    <= '0;
      h_wdata <= '0;
      rdata   <= '0;
    end else begin
      if (load) begin
        h_write <= write;
        h_addr  <= addr;
        h_be    <= be;
        h_wdata <= wdata;
      end
      if (go_sup) rdata <= '0;
      else if (state == XS_T2) rdata <= h_write ? '0 : data_in;
    end
  end

  always_comb begin
    active   = (state == XS_T1) | (state == XS_T2);
    strobe   = (state == XS_T2);
    sel_n    = ~active;
    xaddr    = active ? h_addr : '0;
    rd_n     = ~(strobe & ~h_write);
    data_oe  = active & h_write;
    data_out = data_oe ? h_wdata : '0;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_n[i] = ~(strobe & h_write & h_be[i]);
  end

  // R4: read strobe only inside a select window that began a cycle earlier
  a_r4_rd_in_t2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!sel_n && $past(!sel_n)));
  // R5: data bus driven only while selected
  a_r5_oe_in_sel: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !sel_n);
  // R5: write strobes never coincide with the read strobe
  a_r5_wr_not_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n != {LANES{1'b1}}) |-> (rd_n && data_oe));
endmodule

// File: rtl/port_xbus_seq.sv
module port_xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = XB_ADDR_W,
  parameter int DATA_W = XB_DATA_W,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_onchip,
  input  logic              req_all_in,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              xio_sel_n,
  output logic [ADDR_W-1:0] xio_addr,
  output logic              xio_rd_n,
  output logic [LANES-1:0]  xio_wr_n,
  output logic [DATA_W-1:0] xio_data_out,
  output logic              xio_data_oe,
  input  logic [DATA_W-1:0] xio_data_in
);
  logic      accept, suppress, go_ext, go_sup;
  xs_state_e state;

  assign accept = req_valid & req_ready;
  assign go_ext = accept & ~suppress;
  assign go_sup = accept & suppress;

  xbus_gate u_gate (
    .write    (req_write),
    .onchip   (req_onchip),
    .all_in   (req_all_in),
    .suppress (suppress)
  );

  xbus_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_ext (go_ext),
    .go_sup (go_sup),
    .state  (state),
    .ready  (req_ready),
    .done   (rsp_done)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go_ext),
    .go_sup   (go_sup),
    .write    (req_write),
    .addr     (req_addr),
    .be       (req_be),
    .wdata    (req_wdata),
    .state    (state),
    .data_in  (xio_data_in),
    .rdata    (rsp_rdata),
    .sel_n    (xio_sel_n),
    .xaddr    (xio_addr),
    .rd_n     (xio_rd_n),
    .wr_n     (xio_wr_n),
    .data_out (xio_data_out),
    .data_oe  (xio_data_oe)
  );

  // R6 / R7: a finished-internally request completes next cycle with pins quiet
  a_r6_sup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    go_sup |=> (xio_sel_n && rsp_done && rsp_rdata == '0));
  // R4: the select window always closes together with the done pulse
  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xio_sel_n) |-> rsp_done);
  // R2: busy while the select window is open
  a_r2_busy_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !xio_sel_n |-> !req_ready);
endmodule

// File: tb/sim_port_xbus_seq.sv
module sim_port_xbus_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_onchip, req_all_in;
  logic [7:0]  req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        xio_sel_n, xio_rd_n, xio_data_oe;
  logic [7:0]  xio_addr;
  logic [1:0]  xio_wr_n;
  logic [15:0] xio_data_out, xio_data_in;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  // external device model: data depends on the address it sees
  assign xio_data_in = {~xio_addr, xio_addr};

  port_xbus_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_onchip(req_onchip), .req_all_in(req_all_in),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .xio_sel_n(xio_sel_n), .xio_addr(xio_addr), .xio_rd_n(xio_rd_n),
    .xio_wr_n(xio_wr_n), .xio_data_out(xio_data_out),
    .xio_data_oe(xio_data_oe), .xio_data_in(xio_data_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pins();
    return {xio_sel_n, xio_rd_n, xio_wr_n, xio_data_oe, rsp_done};
  endfunction

  // monitor: pop expected read data at every done pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_done === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected done", 32'(rsp_rdata), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata === e, "R4/R6 rdata", 32'(rsp_rdata), 32'(e));
      end
    end
  end

  // driver: call at a negedge with req_ready high; returns at the done negedge
  task automatic send(input bit w, input logic [7:0] a, input logic [1:0] be,
                      input logic [15:0] wd, input bit onc, input bit allin);
    bit sup;
    sup = onc | (allin & w);
    req_valid = 1; req_write = w; req_addr = a; req_be = be;
    req_wdata = wd; req_onchip = onc; req_all_in = allin;
    exp_q.push_back((!w && !sup) ? {~a, a} : 16'h0);
    @(negedge clk);
    req_valid = 0;
    if (sup) begin
      chk(rsp_done === 1'b1, onc ? "R6 done next cycle" : "R7 done next cycle",
          32'(rsp_done), 1);
      chk(pins() == 6'b111101, onc ? "R6 pins quiet" : "R7 write ignored",
          32'(pins()), 32'h3D);
      return;
    end
    chk(pins() == 6'b111100, "R3 leading idle clock", 32'(pins()), 32'h3C);
    chk(req_ready === 1'b0, "R2 busy in idle clock", 32'(req_ready), 0);
    @(negedge clk);
    chk(xio_sel_n === 0 && xio_addr === a && xio_rd_n === 1 && xio_wr_n === 2'b11,
        "R3 T1 select/address", {xio_sel_n, xio_rd_n, xio_wr_n, xio_addr}, {4'b0111, a});
    chk(xio_data_oe === w && (!w || xio_data_out === wd), "R5 T1 data drive",
        {xio_data_oe, xio_data_out}, {w, wd});
    @(negedge clk);
    chk(xio_sel_n === 0 && xio_addr === a, "R3 T2 select/address",
        {xio_sel_n, xio_addr}, {1'b0, a});
    chk(xio_rd_n === w, "R4 read strobe in T2", 32'(xio_rd_n), 32'(w));
    chk(xio_wr_n === (w ? ~be : 2'b11), "R5 lane write strobes",
        32'(xio_wr_n), 32'(w ? ~be : 2'b11));
    chk(xio_data_oe === w && (!w || xio_data_out === wd), "R5 T2 data drive",
        {xio_data_oe, xio_data_out}, {w, wd});
    chk(req_ready === 1'b0, "R2 busy in T2", 32'(req_ready), 0);
    @(negedge clk);
    chk(rsp_done === 1 && req_ready === 1, "R4 done pulse and ready",
        {rsp_done, req_ready}, 2'b11);
    chk(xio_sel_n === 1 && xio_data_oe === 0, "R8 select released at done",
        {xio_sel_n, xio_data_oe}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_be = 0;
    req_wdata = 0; req_onchip = 0; req_all_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pins() == 6'b111100 && req_ready === 1, "R1 reset state",
        {pins(), req_ready}, {6'b111100, 1'b1});

    // external reads with varied addresses
    send(0, 8'h12, 2'b11, 16'h0, 0, 0);
    send(0, 8'hA5, 2'b00, 16'h0, 0, 0);
    // all-input port read still goes out (R7)
    send(0, 8'h3C, 2'b11, 16'h0, 0, 1);
    // writes with each lane mix (R5)
    send(1, 8'h40, 2'b01, 16'hBEEF, 0, 0);
    send(1, 8'h41, 2'b10, 16'h1234, 0, 0);
    send(1, 8'hFF, 2'b11, 16'hC0DE, 0, 0);
    // suppressed: on-chip read and write (R6), all-input write (R7)
    send(0, 8'h07, 2'b11, 16'h0, 1, 0);
    send(1, 8'h08, 2'b11, 16'h5555, 1, 1);
    send(1, 8'h09, 2'b11, 16'hAAAA, 0, 1);
    // back to back external after suppressed (R8)
    send(0, 8'h81, 2'b11, 16'h0, 0, 0);
    send(1, 8'h82, 2'b11, 16'h0F0F, 0, 0);

    // R2: request held at valid while busy is not taken until done
    req_valid = 1; req_write = 0; req_addr = 8'h66; req_be = 2'b11;
    req_onchip = 0; req_all_in = 0;
    exp_q.push_back({~8'h66, 8'h66});
    @(negedge clk);
    req_addr = 8'h99; req_onchip = 1;
    exp_q.push_back(16'h0);
    @(negedge clk);
    chk(rsp_done === 0 && xio_addr === 8'h66, "R2 held request ignored T1",
        {rsp_done, xio_addr}, {1'b0, 8'h66});
    @(negedge clk);
    chk(rsp_done === 0 && xio_addr === 8'h66, "R2 held request ignored T2",
        {rsp_done, xio_addr}, {1'b0, 8'h66});
    @(negedge clk);
    chk(rsp_done === 1 && req_ready === 1, "R2 first done", {rsp_done, req_ready}, 2'b11);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_done === 1 && xio_sel_n === 1, "R2 held request taken after done",
        {rsp_done, xio_sel_n}, 2'b11);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all completions seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule